// File: doc/BRIEF.md
# Register Integration Table

This block sits beside the rename stage of an out-of-order core and lets the main thread adopt results that a helper thread has already produced. When a helper instruction is renamed, it writes one entry holding its PC, the physical tags of up to two source operands and the physical tag it was given for its result. When a main-thread instruction is renamed, its PC and its current source mappings are presented as a lookup. A match means the helper computed exactly this instruction on exactly these inputs. The rename logic then points the destination logical register at the stored physical register instead of allocating a new one.

The decision uses tags only. No register contents are read, compared or written, and the only effect of a hit is a map-table update made by the surrounding rename logic. Three side effects cover correctness and cleanup. A hit on a branch resolves that branch at rename. A hit on a load flags the load for later re-execution. A load PC whose integration once led to a squash is blocked from integrating again. When an insert displaces an entry, the displaced physical register is handed back to the free list, and any entry that consumed it as a source is dropped.

Top module: `rit_table`

## Requirements
- R1: After reset the table holds no valid entry, and every lookup misses. An asserted `ins_valid` writes an entry, and a lookup in the next cycle can see it.
- R2: A lookup hits only when all of the following hold: the stored PC equals `lk_pc`, the 2-bit source-use mask equals `lk_src_use` (bit 0 for source 0, bit 1 for source 1), and each used source tag equals the presented tag.
- R3: On a hit, `lk_preg` carries the stored result tag. The lookup result is combinational in the same cycle.
- R4: A result tag returned by one hit can serve as a source tag that matches a later entry, so integrations chain along a dependence path.
- R5: The set is selected by PC bits [IDX_W+1:2], where IDX_W is log2(SETS). Each set holds WAYS entries, and the default geometry is 256 sets by 4 ways.
- R6: Within a set, an insert writes the least recently inserted way, and lookups do not change that order. When the overwritten way was valid, `evict_valid` is high in the insert cycle and `evict_preg` names its result tag.
- R7: When an insert displaces a valid entry, every entry that uses the displaced result tag as a source is invalidated at the same clock edge.
- R8: `lk_resolve` is high exactly when a lookup with `lk_is_branch` set hits.
- R9: `lk_reexec` is high exactly when a lookup with `lk_is_load` set hits.
- R10: Once `sq_valid` reports a PC, a later load lookup at that PC misses, even when a matching entry is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Helper instruction insert strobe |
| ins_pc | input | 32 | PC of inserted instruction |
| ins_src_use | input | 2 | Which source tags are meaningful |
| ins_src0 | input | 10 | Physical tag of source 0 |
| ins_src1 | input | 10 | Physical tag of source 1 |
| ins_dst | input | 10 | Physical tag of helper result |
| evict_valid | output | 1 | An insert displaced a valid entry |
| evict_preg | output | 10 | Result tag freed by that displacement |
| lk_valid | input | 1 | Main-thread lookup strobe |
| lk_pc | input | 32 | PC of main-thread instruction |
| lk_src_use | input | 2 | Which lookup source tags are meaningful |
| lk_src0 | input | 10 | Current mapping of source 0 |
| lk_src1 | input | 10 | Current mapping of source 1 |
| lk_is_load | input | 1 | Lookup is a load |
| lk_is_branch | input | 1 | Lookup is a branch |
| lk_hit | output | 1 | Integration permitted |
| lk_preg | output | 10 | Physical tag to map the destination to |
| lk_resolve | output | 1 | Integrated branch resolves at rename |
| lk_reexec | output | 1 | Integrated load needs re-execution |
| sq_valid | input | 1 | An integrated load caused a squash |
| sq_pc | input | 32 | PC of that load |

## Verification
The bench builds the table with 4 sets, 2 ways and a 2-entry squash list. With 2 ways, a third insert into one set forces a displacement within a few cycles, so the least-recently-inserted order, the freed-tag report and the dependent invalidation can all be checked directly. Four sets make it easy to place a producer and its consumer in different sets, which shows that invalidation reaches across the whole table. The dependence chain, the two-source match and the load blacklist are each driven on hand-placed PCs whose set index is known in advance.

// File: rtl/rit_pkg.sv
package rit_pkg;
    localparam int PC_W   = 32;
    localparam int PREG_W = 10;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [PREG_W-1:0] preg_t;

    typedef struct packed {
        logic [1:0] use_mask;
        preg_t      src0;
        preg_t      src1;
    } srcs_t;

    typedef struct packed {
        logic  valid;
        pc_t   pc;
        srcs_t srcs;
        preg_t dst;
    } ent_t;

    function automatic logic srcs_match(srcs_t a, srcs_t b);
        return (a.use_mask == b.use_mask)
            && (!a.use_mask[0] || a.src0 == b.src0)
            && (!a.use_mask[1] || a.src1 == b.src1);
    endfunction

    function automatic logic reads_tag(srcs_t s, preg_t p);
        return (s.use_mask[0] && s.src0 == p) || (s.use_mask[1] && s.src1 == p);
    endfunction
endpackage

// File: rtl/rit_match.sv
module rit_match
    import rit_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  ent_t  ways_i [WAYS],
    input  pc_t   pc_i,
    input  srcs_t srcs_i,
    output logic  hit_o,
    output preg_t preg_o
);
    logic [WAYS-1:0] way_hit;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = ways_i[w].valid && (ways_i[w].pc == pc_i)
                          && srcs_match(ways_i[w].srcs, srcs_i);
    end

    always_comb begin
        hit_o  = 1'b0;
        preg_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit_o  = 1'b1;
                preg_o = ways_i[w].dst;
            end
        end
    end
endmodule

// File: rtl/rit_victim.sv
module rit_victim #(
    parameter int SETS = 256,
    parameter int WAYS = 4,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic [IDX_W-1:0] set_i,
    output logic [WAY_W-1:0] way_o
);
    logic [WAY_W-1:0] order_q [SETS];

    assign way_o = order_q[set_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) order_q[s] <= '0;
        end else if (adv_i) begin
            if (order_q[set_i] == WAY_W'(WAYS - 1)) order_q[set_i] <= '0;
            else order_q[set_i] <= order_q[set_i] + 1'b1;
        end
    end
endmodule

// File: rtl/rit_blacklist.sv
module rit_blacklist
    import rit_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic add_i,
    input  pc_t  add_pc_i,
    input  pc_t  query_pc_i,
    output logic listed_o
);
    pc_t             pc_q  [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [PTR_W-1:0] wr_q;
    logic [DEPTH-1:0] eq;

    for (genvar i = 0; i < DEPTH; i++) begin : g_eq
        assign eq[i] = vld_q[i] && (pc_q[i] == query_pc_i);
    end
    assign listed_o = |eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            wr_q  <= '0;
            for (int i = 0; i < DEPTH; i++) pc_q[i] <= '0;
        end else if (add_i) begin
            pc_q[wr_q]  <= add_pc_i;
            vld_q[wr_q] <= 1'b1;
            if (wr_q == PTR_W'(DEPTH - 1)) wr_q <= '0;
            else wr_q <= wr_q + 1'b1;
        end
    end
endmodule

// File: rtl/rit_table.sv
module rit_table
    import rit_pkg::*;
#(
    parameter int SETS     = 256,
    parameter int WAYS     = 4,
    parameter int BL_DEPTH = 8,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ins_valid,
    input  logic [rit_pkg::PC_W-1:0]   ins_pc,
    input  logic [1:0]               ins_src_use,
    input  logic [rit_pkg::PREG_W-1:0] ins_src0,
    input  logic [rit_pkg::PREG_W-1:0] ins_src1,
    input  logic [rit_pkg::PREG_W-1:0] ins_dst,
    output logic                     evict_valid,
    output logic [rit_pkg::PREG_W-1:0] evict_preg,
    input  logic                     lk_valid,
    input  logic [rit_pkg::PC_W-1:0]   lk_pc,
    input  logic [1:0]               lk_src_use,
    input  logic [rit_pkg::PREG_W-1:0] lk_src0,
    input  logic [rit_pkg::PREG_W-1:0] lk_src1,
    input  logic                     lk_is_load,
    input  logic                     lk_is_branch,
    output logic                     lk_hit,
    output logic [rit_pkg::PREG_W-1:0] lk_preg,
    output logic                     lk_resolve,
    output logic                     lk_reexec,
    input  logic                     sq_valid,
    input  logic [rit_pkg::PC_W-1:0]   sq_pc
);
    ent_t tbl [SETS][WAYS];

    logic [IDX_W-1:0] ins_set, lk_set;
    logic [WAY_W-1:0] vic_way;
    ent_t             victim, new_ent;
    srcs_t            lk_srcs;
    logic             raw_hit, listed;
    preg_t            raw_preg;

    assign ins_set = ins_pc[IDX_W+1:2];
    assign lk_set  = lk_pc[IDX_W+1:2];

    assign new_ent.valid         = 1'b1;
    assign new_ent.pc            = ins_pc;
    assign new_ent.srcs.use_mask = ins_src_use;
    assign new_ent.srcs.src0     = ins_src0;
    assign new_ent.srcs.src1     = ins_src1;
    assign new_ent.dst           = ins_dst;

    assign lk_srcs.use_mask = lk_src_use;
    assign lk_srcs.src0     = lk_src0;
    assign lk_srcs.src1     = lk_src1;

    rit_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk  (clk),
        .rst  (rst),
        .adv_i(ins_valid),
        .set_i(ins_set),
        .way_o(vic_way)
    );

    assign victim      = tbl[ins_set][vic_way];
    assign evict_valid = ins_valid && victim.valid;
    assign evict_preg  = victim.dst;

    rit_match #(.WAYS(WAYS)) u_match (
        .ways_i(tbl[lk_set]),
        .pc_i  (lk_pc),
        .srcs_i(lk_srcs),
        .hit_o (raw_hit),
        .preg_o(raw_preg)
    );

    rit_blacklist #(.DEPTH(BL_DEPTH)) u_bl (
        .clk       (clk),
        .rst       (rst),
        .add_i     (sq_valid),
        .add_pc_i  (sq_pc),
        .query_pc_i(lk_pc),
        .listed_o  (listed)
    );

    assign lk_hit     = lk_valid && raw_hit && !(lk_is_load && listed);
    assign lk_preg    = raw_preg;
    assign lk_resolve = lk_hit && lk_is_branch;
    assign lk_reexec  = lk_hit && lk_is_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    tbl[s][w] <= '0;
        end else if (ins_valid) begin
            if (victim.valid) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        if (reads_tag(tbl[s][w].srcs, victim.dst))
                            tbl[s][w].valid <= 1'b0;
            end
            tbl[ins_set][vic_way] <= new_ent;
        end
    end
endmodule

// File: rtl/rit_table_chk.sv
module rit_table_chk
    import rit_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        ins_valid,
    input logic [PC_W-1:0]   ins_pc,
    input logic [1:0]        ins_src_use,
    input logic [PREG_W-1:0] ins_src0,
    input logic [PREG_W-1:0] ins_src1,
    input logic [PREG_W-1:0] ins_dst,
    input logic        evict_valid,
    input logic [PREG_W-1:0] evict_preg,
    input logic        lk_valid,
    input logic [PC_W-1:0]   lk_pc,
    input logic [1:0]        lk_src_use,
    input logic [PREG_W-1:0] lk_src0,
    input logic [PREG_W-1:0] lk_src1,
    input logic        lk_is_load,
    input logic        lk_is_branch,
    input logic        lk_hit,
    input logic [PREG_W-1:0] lk_preg,
    input logic        lk_resolve,
    input logic        lk_reexec,
    input logic        sq_valid,
    input logic [PC_W-1:0]   sq_pc
);
    p_hit_needs_lookup_r2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_valid);

    p_insert_visible_r1: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=> ((lk_valid && !lk_is_load && lk_pc == $past(ins_pc)
                        && lk_src_use == $past(ins_src_use)
                        && lk_src0 == $past(ins_src0)
                        && lk_src1 == $past(ins_src1)) -> lk_hit));

    p_evict_on_insert_r6: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> ins_valid);

    p_resolve_branch_r8: assert property (@(posedge clk) disable iff (rst)
        lk_resolve |-> (lk_hit && lk_is_branch));

    p_reexec_load_r9: assert property (@(posedge clk) disable iff (rst)
        lk_reexec |-> (lk_hit && lk_is_load));

    p_squashed_pc_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> !(lk_hit && lk_is_load && lk_pc == $past(sq_pc)));
endmodule

bind rit_table rit_table_chk u_chk (.*);

// File: tb/rit_table_test.sv
module rit_table_test;
    import rit_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic ins_valid;
    logic [PC_W-1:0]   ins_pc;
    logic [1:0]        ins_src_use;
    logic [PREG_W-1:0] ins_src0, ins_src1, ins_dst;
    logic              evict_valid;
    logic [PREG_W-1:0] evict_preg;
    logic              lk_valid;
    logic [PC_W-1:0]   lk_pc;
    logic [1:0]        lk_src_use;
    logic [PREG_W-1:0] lk_src0, lk_src1;
    logic              lk_is_load, lk_is_branch;
    logic              lk_hit;
    logic [PREG_W-1:0] lk_preg;
    logic              lk_resolve, lk_reexec;
    logic              sq_valid;
    logic [PC_W-1:0]   sq_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rit_table #(.SETS(4), .WAYS(2), .BL_DEPTH(2)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_insert(input int pc, input int use_m, input int s0, input int s1,
                             input int dst, input bit exp_ev, input int exp_preg,
                             input string req);
        @(negedge clk);
        ins_valid = 1'b1; ins_pc = pc; ins_src_use = use_m[1:0];
        ins_src0 = s0[PREG_W-1:0]; ins_src1 = s1[PREG_W-1:0]; ins_dst = dst[PREG_W-1:0];
        #1;
        chk(evict_valid == exp_ev, req, int'(evict_valid), int'(exp_ev));
        if (exp_ev) chk(int'(evict_preg) == exp_preg, req, int'(evict_preg), exp_preg);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic do_lookup(input int pc, input int use_m, input int s0, input int s1,
                             input bit ld, input bit br, input bit exp_hit, input int exp_preg,
                             input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; lk_src_use = use_m[1:0];
        lk_src0 = s0[PREG_W-1:0]; lk_src1 = s1[PREG_W-1:0];
        lk_is_load = ld; lk_is_branch = br;
        #1;
        chk(lk_hit == exp_hit, req, int'(lk_hit), int'(exp_hit));
        if (exp_hit) chk(int'(lk_preg) == exp_preg, req, int'(lk_preg), exp_preg);
        chk(lk_resolve == (exp_hit && br), {req, " resolve"}, int'(lk_resolve), int'(exp_hit && br));
        chk(lk_reexec == (exp_hit && ld), {req, " reexec"}, int'(lk_reexec), int'(exp_hit && ld));
        @(negedge clk);
        lk_valid = 1'b0; lk_is_load = 1'b0; lk_is_branch = 1'b0;
    endtask

    task automatic t_reset;
        do_lookup(32'h10, 1, 7, 0, 0, 0, 0, 0, "R1 empty after reset");
        chk(evict_valid == 1'b0, "R1 no evict at idle", int'(evict_valid), 0);
    endtask

    task automatic t_basic;
        // set 0 (pc[3:2]=0)
        do_insert(32'h10, 1, 7, 0, 6, 0, 0, "R1 first insert");
        do_lookup(32'h10, 1, 7, 0, 0, 0, 1, 6, "R3 hit returns stored tag");
        do_lookup(32'h10, 1, 8, 0, 0, 0, 0, 0, "R2 source tag mismatch");
        do_lookup(32'h30, 1, 7, 0, 0, 0, 0, 0, "R2 pc mismatch same set");
        do_lookup(32'h10, 3, 7, 0, 0, 0, 0, 0, "R2 use mask mismatch");
    endtask

    task automatic t_chain;
        do_insert(32'h20, 1, 6, 0, 9, 0, 0, "R4 dependent insert");
        do_lookup(32'h10, 1, 7, 0, 0, 0, 1, 6, "R4 first link");
        do_lookup(32'h20, 1, 6, 0, 0, 1, 1, 9, "R4 R8 second link branch");
        do_lookup(32'h20, 1, 5, 0, 0, 1, 0, 0, "R8 miss branch no resolve");
    endtask

    task automatic t_replace;
        // set 1
        do_insert(32'h04, 1, 10, 0, 20, 0, 0, "R5 set1 way0");
        do_insert(32'h14, 3, 3, 4, 21, 0, 0, "R5 set1 way1");
        do_lookup(32'h14, 3, 3, 4, 0, 0, 1, 21, "R2 two-source hit");
        do_lookup(32'h14, 3, 3, 5, 0, 0, 0, 0, "R2 second source mismatch");
        do_lookup(32'h04, 1, 10, 0, 0, 0, 1, 20, "R6 hit before replace");
        do_insert(32'h24, 1, 11, 0, 22, 1, 20, "R6 evict oldest despite hit");
        do_lookup(32'h04, 1, 10, 0, 0, 0, 0, 0, "R6 oldest gone");
        do_lookup(32'h14, 3, 3, 4, 0, 0, 1, 21, "R6 younger kept");
        do_lookup(32'h24, 1, 11, 0, 0, 0, 1, 22, "R6 new present");
    endtask

    task automatic t_invalidate;
        do_insert(32'h08, 1, 1, 0, 30, 0, 0, "R7 producer set2");
        do_insert(32'h0C, 1, 30, 0, 31, 0, 0, "R7 consumer set3");
        do_lookup(32'h0C, 1, 30, 0, 0, 0, 1, 31, "R7 consumer before");
        do_insert(32'h18, 1, 1, 0, 32, 0, 0, "R7 fill set2");
        do_insert(32'h28, 1, 1, 0, 33, 1, 30, "R7 displace producer");
        do_lookup(32'h0C, 1, 30, 0, 0, 0, 0, 0, "R7 consumer invalidated");
        do_lookup(32'h18, 1, 1, 0, 0, 0, 1, 32, "R7 unrelated kept");
    endtask

    task automatic t_load;
        do_insert(32'h1C, 1, 2, 0, 40, 0, 0, "R9 load insert set3");
        do_lookup(32'h1C, 1, 2, 0, 1, 0, 1, 40, "R9 load hit reexec");
        @(negedge clk);
        sq_valid = 1'b1; sq_pc = 32'h1C;
        @(negedge clk);
        sq_valid = 1'b0;
        do_lookup(32'h1C, 1, 2, 0, 1, 0, 0, 0, "R10 blacklisted load");
        do_lookup(32'h28, 1, 1, 0, 1, 0, 1, 33, "R10 other load unaffected");
    endtask

    initial begin
        rst = 1'b1; ins_valid = 1'b0; ins_pc = '0; ins_src_use = '0;
        ins_src0 = '0; ins_src1 = '0; ins_dst = '0;
        lk_valid = 1'b0; lk_pc = '0; lk_src_use = '0; lk_src0 = '0; lk_src1 = '0;
        lk_is_load = 1'b0; lk_is_branch = 1'b0; sq_valid = 1'b0; sq_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_chain();
        t_replace();
        t_invalidate();
        t_load();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule